// File: doc/BRIEF.md
# Pipelined Instruction Fetch Stage

This block is the first stage of a 32-bit RISC pipeline. Each cycle it decides the address of the next instruction word: the current program counter plus four in straight-line flow, the same address again while a stall is requested, or a target handed back by a later stage when a branch or jump is taken. A taken redirect always wins over a stall.

The instruction store models a memory whose address input is registered, and that address register is part of the stage's pipeline register. The register is therefore loaded from the computed next address, the same value that enters the program counter register, so the two always agree. The fetched word and its program counter leave the stage together in the same cycle. The program counter resets to 0xFFFFFFFC, so the first fetch after reset comes from address 0. A write port lets the environment load program words, normally while reset is held.

Top module: `fetch_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `pc` becomes 0xFFFFFFFC; at the first rising edge with `rst` low, `pc` becomes 0x00000000.
- R2: With `redirect_valid` and `stall` both low, `pc` after a rising edge equals the previous `pc` plus 4, modulo 2^32.
- R3: `instr` always equals the memory word whose index is `pc[9:2]`, so the word and its address are presented in the same cycle.
- R4: With `redirect_valid` high, `pc` after the rising edge equals `redirect_target` sampled at that edge.
- R5: With `stall` high and `redirect_valid` low, `pc` and `instr` keep their values across the rising edge.
- R6: When `redirect_valid` and `stall` are both high, the redirect is taken: `pc` becomes `redirect_target`.
- R7: With `wr_en` high at a rising edge, the 32-bit `wr_data` is stored at word index `wr_addr` and is seen by any later fetch of that index.
- R8: Only address bits [9:2] select the word, so addresses 1024 bytes apart fetch the same word (0x400 fetches word 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| stall | input | 1 | Hold program counter and fetch address |
| redirect_valid | input | 1 | Taken branch or jump from a later stage |
| redirect_target | input | 32 | Byte address to fetch next when redirecting |
| wr_en | input | 1 | Instruction memory write strobe |
| wr_addr | input | 8 | Word index to write |
| wr_data | input | 32 | Word to write |
| pc | output | 32 | Address of the instruction on `instr` |
| instr | output | 32 | Fetched instruction word |

## Verification
The hardest situation to reach is the simultaneous arrival of a stall and a redirect, together with the wrap of the program counter past the end of the 1 KiB store, since neither appears in plain sequential flow. The bench preloads every word with a value derived from its index, then drives a redirect with stall held high and a redirect to the last word followed by a free-running step, so both the priority and the aliasing show up directly on `pc` and `instr`. A write to a word just ahead of the fetch point, issued in the same cycle as a redirect, checks that a fresh store is visible to the very next fetch.

// File: rtl/fetch_unit.sv
module fetch_unit #(
  parameter int XLEN      = 32,
  parameter int MEM_WORDS = 256,
  parameter int IDX_W     = $clog2(MEM_WORDS),
  parameter logic [XLEN-1:0] RESET_PC = {{(XLEN-2){1'b1}}, 2'b00}
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            stall,
  input  logic            redirect_valid,
  input  logic [XLEN-1:0] redirect_target,
  input  logic            wr_en,
  input  logic [IDX_W-1:0] wr_addr,
  input  logic [XLEN-1:0] wr_data,
  output logic [XLEN-1:0] pc,
  output logic [XLEN-1:0] instr
);

  localparam int IDX_LO = 2;
  localparam int IDX_HI = IDX_LO + IDX_W - 1;

  logic [XLEN-1:0]  pc_q;
  logic [IDX_W-1:0] addr_q;
  logic [XLEN-1:0]  seq_pc;
  logic [XLEN-1:0]  next_pc;
  logic [XLEN-1:0]  mem [MEM_WORDS];

  assign seq_pc  = stall ? pc_q : pc_q + XLEN'(4);
  assign next_pc = redirect_valid ? redirect_target : seq_pc;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q   <= RESET_PC;
      addr_q <= RESET_PC[IDX_HI:IDX_LO];
    end else begin
      pc_q   <= next_pc;
      addr_q <= next_pc[IDX_HI:IDX_LO];
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign instr = mem[addr_q];
  assign pc    = pc_q;

endmodule

// File: rtl/fetch_unit_chk.sv
module fetch_unit_chk #(
  parameter int XLEN  = 32,
  parameter int IDX_W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            stall,
  input logic            redirect_valid,
  input logic [XLEN-1:0] redirect_target,
  input logic [XLEN-1:0] pc,
  input logic [IDX_W-1:0] addr_idx
);

  a_r1_reset_value: assert property (@(posedge clk)
    rst |=> pc == {{(XLEN-2){1'b1}}, 2'b00});

  a_r2_sequential: assert property (@(posedge clk) disable iff (rst)
    (!stall && !redirect_valid) |=> pc == $past(pc) + XLEN'(4));

  a_r3_addr_matches_pc: assert property (@(posedge clk) disable iff (rst)
    addr_idx == pc[IDX_W+1:2]);

  a_r4_redirect: assert property (@(posedge clk) disable iff (rst)
    redirect_valid |=> pc == $past(redirect_target));

  a_r5_stall_hold: assert property (@(posedge clk) disable iff (rst)
    (stall && !redirect_valid) |=> $stable(pc));

  a_r6_redirect_beats_stall: assert property (@(posedge clk) disable iff (rst)
    (stall && redirect_valid) |=> pc == $past(redirect_target));

endmodule

bind fetch_unit fetch_unit_chk #(.XLEN(XLEN), .IDX_W(IDX_W)) chk_i (
  .clk(clk),
  .rst(rst),
  .stall(stall),
  .redirect_valid(redirect_valid),
  .redirect_target(redirect_target),
  .pc(pc),
  .addr_idx(addr_q)
);

// File: tb/fetch_unit_tb_top.sv
`timescale 1ns/1ps
module fetch_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stall = 1'b0;
  logic        redirect_valid = 1'b0;
  logic [31:0] redirect_target = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] pc;
  logic [31:0] instr;

  int checks = 0;
  int failures = 0;
  logic [31:0] model [256];

  always #2.5 clk = ~clk;

  fetch_unit dut_i (
    .clk(clk), .rst(rst), .stall(stall),
    .redirect_valid(redirect_valid), .redirect_target(redirect_target),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pc(pc), .instr(instr)
  );

  function automatic logic [31:0] pattern(input int i);
    logic [7:0] b = 8'(i);
    return {8'hC3, b, ~b, b ^ 8'h5A};
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%08h expected=%08h", req, what, act, exp);
    end
  endtask

  task automatic check_fetch(input string req, input logic [31:0] exp_pc);
    check(req, "pc", pc, exp_pc);
    check("R3", "instr", instr, model[exp_pc[9:2]]);
  endtask

  task automatic t_preload_and_reset();
    for (int i = 0; i < 256; i++) begin
      model[i] = pattern(i);
      wr_en = 1'b1; wr_addr = 8'(i); wr_data = model[i];
      step();
    end
    wr_en = 1'b0;
    check("R1", "pc in reset", pc, 32'hFFFF_FFFC);
    rst = 1'b0;
    step();
    check_fetch("R1", 32'h0000_0000);
  endtask

  task automatic t_sequential();
    for (int k = 1; k <= 6; k++) begin
      step();
      check_fetch("R2", 32'(k * 4));
    end
  endtask

  task automatic t_redirect();
    redirect_valid = 1'b1; redirect_target = 32'h0000_0080;
    step();
    redirect_valid = 1'b0;
    check_fetch("R4", 32'h0000_0080);
    step();
    check_fetch("R2", 32'h0000_0084);
  endtask

  task automatic t_stall();
    logic [31:0] held_instr = instr;
    stall = 1'b1;
    for (int k = 0; k < 3; k++) begin
      step();
      check("R5", "pc held", pc, 32'h0000_0084);
      check("R5", "instr held", instr, held_instr);
    end
    redirect_valid = 1'b1; redirect_target = 32'h0000_0200;
    step();
    redirect_valid = 1'b0; stall = 1'b0;
    check_fetch("R6", 32'h0000_0200);
  endtask

  task automatic t_wrap();
    redirect_valid = 1'b1; redirect_target = 32'h0000_03FC;
    step();
    redirect_valid = 1'b0;
    check_fetch("R8", 32'h0000_03FC);
    step();
    check("R8", "pc", pc, 32'h0000_0400);
    check("R8", "instr alias of word 0", instr, model[0]);
  endtask

  task automatic t_write();
    redirect_valid = 1'b1; redirect_target = 32'h0000_0010;
    wr_en = 1'b1; wr_addr = 8'd5; wr_data = 32'hDEAD_BEEF;
    model[5] = 32'hDEAD_BEEF;
    step();
    redirect_valid = 1'b0; wr_en = 1'b0;
    check_fetch("R4", 32'h0000_0010);
    step();
    check("R7", "pc", pc, 32'h0000_0014);
    check("R7", "written word fetched", instr, 32'hDEAD_BEEF);
  endtask

  initial begin
    t_preload_and_reset();
    t_sequential();
    t_redirect();
    t_stall();
    t_wrap();
    t_write();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    checks++;
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule